// File: doc/BRIEF.md
# Split-Word Adder Datapath

This block is the arithmetic core of a small word-serial machine. Each clock it takes a set of control fields. It picks an X operand and a Y operand from the register file, the incoming memory word or fixed zero. It can invert X, adds the two operands with a carry-in chosen by the carry field, and writes the sum into one half of the accumulator, the multiplier register or the product register. Double-length quantities live as a low and a high half of each register. A two-word operation runs as two steps: the low half first with an explicit carry-in, then the high half using the carry kept from the low step. Add, subtract, clear and double-length arithmetic all come from the same adder.

The multiplication sequencer and the memory interface sit outside. The sequencer supplies the current multiplier-step bit and a first-step flag. The memory side receives the raw X operand of the previous step, which is the value a store instruction writes. Every register output is updated on the clock edge that follows the control fields.

Top module: `split_word_alu`

## Requirements
- R1: A synchronous active-high reset clears all six register halves, the saved carry and the memory write word to zero.
- R2: X select codes: 3'b000 gives zero, 3'b100 the accumulator, 3'b010 the memory word, 3'b110 the multiplier register when the step bit is 1 (zero when it is 0), 3'b001 the product register; any other code gives zero.
- R3: Y select codes: 2'b00 gives zero, 2'b10 the accumulator, 2'b01 the bitwise AND of the multiplier register and the memory word, 2'b11 the product register.
- R4: When Y selects the product register (2'b11) and the first-step flag is 1, Y is zero.
- R5: Carry field: 2'b00 gives carry-in 0, 2'b10 carry-in 1, 2'b01 the saved carry; the unused code 2'b11 gives carry-in 0.
- R6: With the invert bit set, X is bitwise complemented before the add. Complemented X with carry-in 1 yields Y minus X. Complemented accumulator plus accumulator plus 1 writes zero.
- R7: Write field: 2'b10 writes the accumulator, 2'b01 the multiplier register, 2'b11 the product register; 2'b00 writes no register.
- R8: The half-select input chooses the low (0) or high (1) half of every register, both for operand reads and for the write; the other half is unchanged.
- R9: The adder carry-out is saved on each step whose write field is non-zero and is held across steps with write field 2'b00. This makes two-word add and subtract correct across the half boundary.
- R10: The memory write word equals the X operand of the previous step, taken before complementing.
- R11: All outputs change only at a clock edge, one cycle after the control fields that cause the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_word | input | W | Word read from memory |
| x_sel | input | 3 | X operand select |
| x_inv | input | 1 | Complement X |
| y_sel | input | 2 | Y operand select |
| cy_mode | input | 2 | Carry-in mode |
| wr_sel | input | 2 | Destination register |
| half_hi | input | 1 | 0 = low half, 1 = high half |
| step_bit | input | 1 | Multiplier-step bit gating the multiply X source |
| first_step | input | 1 | First multiplication step; zeroes the product Y source |
| acc_lo | output | W | Accumulator low half |
| acc_hi | output | W | Accumulator high half |
| mr_lo | output | W | Multiplier register low half |
| mr_hi | output | W | Multiplier register high half |
| pr_lo | output | W | Product register low half |
| pr_hi | output | W | Product register high half |
| mem_wdata | output | W | Value to be written to memory |

## Verification
The hardest case to reach from the ports is the saved carry. It is only visible through the high-half result of a later step, and it must survive an intervening step that writes nothing. The stimulus loads the accumulator with an all-ones low half and then adds one, which produces a carry. An idle step with write field 2'b00 follows, and then the high half is added in saved-carry mode. A borrow case is built the same way through a subtract that crosses the half boundary. After that, a step with the unused carry code is run while the saved carry is 1, which exposes any design that reads the saved carry for that code.

// File: rtl/split_word_alu_pkg.sv
package split_word_alu_pkg;
  localparam logic [2:0] XS_ZERO = 3'b000;
  localparam logic [2:0] XS_ACC  = 3'b100;
  localparam logic [2:0] XS_MEM  = 3'b010;
  localparam logic [2:0] XS_MUL  = 3'b110;
  localparam logic [2:0] XS_PRD  = 3'b001;

  localparam logic [1:0] YS_ZERO = 2'b00;
  localparam logic [1:0] YS_ACC  = 2'b10;
  localparam logic [1:0] YS_AND  = 2'b01;
  localparam logic [1:0] YS_PRD  = 2'b11;

  localparam logic [1:0] CY_ZERO = 2'b00;
  localparam logic [1:0] CY_ONE  = 2'b10;
  localparam logic [1:0] CY_KEEP = 2'b01;

  localparam logic [1:0] WR_NONE = 2'b00;
  localparam logic [1:0] WR_ACC  = 2'b10;
  localparam logic [1:0] WR_MR   = 2'b01;
  localparam logic [1:0] WR_PR   = 2'b11;

  localparam int NUM_REGS = 3;
  localparam int IDX_ACC  = 0;
  localparam int IDX_MR   = 1;
  localparam int IDX_PR   = 2;
endpackage

// File: rtl/x_operand_mux.sv
module x_operand_mux
  import split_word_alu_pkg::*;
#(
  parameter int W = 18
) (
  input  logic [2:0]   sel,
  input  logic         step_bit,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] mem,
  input  logic [W-1:0] mr,
  input  logic [W-1:0] pr,
  output logic [W-1:0] x_raw
);
  always_comb begin
    unique case (sel)
      XS_ACC:  x_raw = acc;
      XS_MEM:  x_raw = mem;
      XS_MUL:  x_raw = step_bit ? mr : '0;
      XS_PRD:  x_raw = pr;
      default: x_raw = '0;
    endcase
  end
endmodule

// File: rtl/y_operand_mux.sv
module y_operand_mux
  import split_word_alu_pkg::*;
#(
  parameter int W = 18
) (
  input  logic [1:0]   sel,
  input  logic         first_step,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] mem,
  input  logic [W-1:0] mr,
  input  logic [W-1:0] pr,
  output logic [W-1:0] y_op
);
  always_comb begin
    unique case (sel)
      YS_ACC:  y_op = acc;
      YS_AND:  y_op = mr & mem;
      YS_PRD:  y_op = first_step ? '0 : pr;
      default: y_op = '0;
    endcase
  end
endmodule

// File: rtl/ripple_adder.sv
module ripple_adder #(
  parameter int W = 18
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] c;
  assign c[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]  = a[i] ^ b[i] ^ c[i];
    assign c[i+1]  = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
  end

  assign cout = c[W];
endmodule

// File: rtl/half_reg_bank.sv
module half_reg_bank
  import split_word_alu_pkg::*;
#(
  parameter int W = 18,
  parameter int N = NUM_REGS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        we,
  input  logic                half_hi,
  input  logic [W-1:0]        wdata,
  output logic [N-1:0][W-1:0] lo_q,
  output logic [N-1:0][W-1:0] hi_q
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    logic [W-1:0] lo_r;
    logic [W-1:0] hi_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_r <= '0;
        hi_r <= '0;
      end else if (we[g]) begin
        if (half_hi) hi_r <= wdata;
        else         lo_r <= wdata;
      end
    end

    assign lo_q[g] = lo_r;
    assign hi_q[g] = hi_r;
  end
endmodule

// File: rtl/split_word_alu.sv
module split_word_alu
  import split_word_alu_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] mem_word,
  input  logic [2:0]   x_sel,
  input  logic         x_inv,
  input  logic [1:0]   y_sel,
  input  logic [1:0]   cy_mode,
  input  logic [1:0]   wr_sel,
  input  logic         half_hi,
  input  logic         step_bit,
  input  logic         first_step,
  output logic [W-1:0] acc_lo,
  output logic [W-1:0] acc_hi,
  output logic [W-1:0] mr_lo,
  output logic [W-1:0] mr_hi,
  output logic [W-1:0] pr_lo,
  output logic [W-1:0] pr_hi,
  output logic [W-1:0] mem_wdata
);
  logic [NUM_REGS-1:0][W-1:0] lo_q, hi_q;
  logic [NUM_REGS-1:0]        we;
  logic [W-1:0] acc_cur, mr_cur, pr_cur;
  logic [W-1:0] x_raw, x_op, y_op, sum;
  logic         cin, cout, carry_q;
  logic [W-1:0] mem_q;

  assign acc_cur = half_hi ? hi_q[IDX_ACC] : lo_q[IDX_ACC];
  assign mr_cur  = half_hi ? hi_q[IDX_MR]  : lo_q[IDX_MR];
  assign pr_cur  = half_hi ? hi_q[IDX_PR]  : lo_q[IDX_PR];

  x_operand_mux #(.W(W)) u_xmux (
    .sel(x_sel), .step_bit(step_bit), .acc(acc_cur), .mem(mem_word),
    .mr(mr_cur), .pr(pr_cur), .x_raw(x_raw)
  );

  y_operand_mux #(.W(W)) u_ymux (
    .sel(y_sel), .first_step(first_step), .acc(acc_cur), .mem(mem_word),
    .mr(mr_cur), .pr(pr_cur), .y_op(y_op)
  );

  assign x_op = x_inv ? ~x_raw : x_raw;

  always_comb begin
    unique case (cy_mode)
      CY_ONE:  cin = 1'b1;
      CY_KEEP: cin = carry_q;
      default: cin = 1'b0;
    endcase
  end

  ripple_adder #(.W(W)) u_add (
    .a(x_op), .b(y_op), .cin(cin), .sum(sum), .cout(cout)
  );

  always_comb begin
    we = '0;
    unique case (wr_sel)
      WR_ACC:  we[IDX_ACC] = 1'b1;
      WR_MR:   we[IDX_MR]  = 1'b1;
      WR_PR:   we[IDX_PR]  = 1'b1;
      default: we = '0;
    endcase
  end

  half_reg_bank #(.W(W), .N(NUM_REGS)) u_bank (
    .clk(clk), .rst(rst), .we(we), .half_hi(half_hi), .wdata(sum),
    .lo_q(lo_q), .hi_q(hi_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q <= 1'b0;
      mem_q   <= '0;
    end else begin
      if (wr_sel != WR_NONE) carry_q <= cout;
      mem_q <= x_raw;
    end
  end

  assign acc_lo    = lo_q[IDX_ACC];
  assign acc_hi    = hi_q[IDX_ACC];
  assign mr_lo     = lo_q[IDX_MR];
  assign mr_hi     = hi_q[IDX_MR];
  assign pr_lo     = lo_q[IDX_PR];
  assign pr_hi     = hi_q[IDX_PR];
  assign mem_wdata = mem_q;
endmodule

// File: rtl/split_word_alu_chk.sv
module split_word_alu_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] mem_word,
  input logic [2:0]   x_sel,
  input logic         x_inv,
  input logic [1:0]   y_sel,
  input logic [1:0]   cy_mode,
  input logic [1:0]   wr_sel,
  input logic         half_hi,
  input logic         step_bit,
  input logic         first_step,
  input logic [W-1:0] acc_lo,
  input logic [W-1:0] acc_hi,
  input logic [W-1:0] mr_lo,
  input logic [W-1:0] mr_hi,
  input logic [W-1:0] pr_lo,
  input logic [W-1:0] pr_hi,
  input logic [W-1:0] mem_wdata
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (acc_lo == '0 && acc_hi == '0 && mr_lo == '0 &&
                    mr_hi == '0 && pr_lo == '0 && pr_hi == '0 && mem_wdata == '0));

  // R7
  no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wr_sel == 2'b00 |=> ($stable(acc_lo) && $stable(acc_hi) && $stable(mr_lo) &&
                         $stable(mr_hi) && $stable(pr_lo) && $stable(pr_hi)));

  // R7
  acc_write_only_chk: assert property (@(posedge clk) disable iff (rst)
    wr_sel == 2'b10 |=> ($stable(mr_lo) && $stable(mr_hi) &&
                         $stable(pr_lo) && $stable(pr_hi)));

  // R8
  low_half_keeps_high_chk: assert property (@(posedge clk) disable iff (rst)
    !half_hi |=> ($stable(acc_hi) && $stable(mr_hi) && $stable(pr_hi)));

  // R10
  mem_gets_acc_chk: assert property (@(posedge clk) disable iff (rst)
    (x_sel == 3'b100 && !half_hi) |=> mem_wdata == $past(acc_lo));

  // R6
  clear_gives_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (x_sel == 3'b100 && x_inv && y_sel == 2'b10 && cy_mode == 2'b10 &&
     wr_sel == 2'b10 && !half_hi) |=> acc_lo == '0);

  // R4
  first_step_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (x_sel == 3'b000 && y_sel == 2'b11 && first_step && cy_mode == 2'b00 &&
     wr_sel == 2'b11 && !half_hi) |=> pr_lo == '0);
endmodule

bind split_word_alu split_word_alu_chk #(.W(W)) u_chk (.*);

// File: tb/test_split_word_alu.sv
module test_split_word_alu;
  localparam int W = 18;
  localparam logic [W-1:0] ONES = '1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] mem_word = '0;
  logic [2:0]   x_sel = 3'b000;
  logic         x_inv = 1'b0;
  logic [1:0]   y_sel = 2'b00;
  logic [1:0]   cy_mode = 2'b00;
  logic [1:0]   wr_sel = 2'b00;
  logic         half_hi = 1'b0;
  logic         step_bit = 1'b0;
  logic         first_step = 1'b0;
  logic [W-1:0] acc_lo, acc_hi, mr_lo, mr_hi, pr_lo, pr_hi, mem_wdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  split_word_alu #(.W(W)) i_split_word_alu (
    .clk(clk), .rst(rst), .mem_word(mem_word), .x_sel(x_sel), .x_inv(x_inv),
    .y_sel(y_sel), .cy_mode(cy_mode), .wr_sel(wr_sel), .half_hi(half_hi),
    .step_bit(step_bit), .first_step(first_step),
    .acc_lo(acc_lo), .acc_hi(acc_hi), .mr_lo(mr_lo), .mr_hi(mr_hi),
    .pr_lo(pr_lo), .pr_hi(pr_hi), .mem_wdata(mem_wdata)
  );

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge; applies one step and returns at the next falling edge.
  task automatic step(input logic [2:0] xs, input logic inv, input logic [1:0] ys,
                      input logic [1:0] cy, input logic [1:0] wr, input logic hi,
                      input logic [W-1:0] m, input logic sb = 1'b0, input logic fs = 1'b0);
    x_sel = xs; x_inv = inv; y_sel = ys; cy_mode = cy; wr_sel = wr;
    half_hi = hi; mem_word = m; step_bit = sb; first_step = fs;
    @(posedge clk);
    @(negedge clk);
    wr_sel = 2'b00;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "acc_lo", acc_lo, '0);
    chk("R1", "acc_hi", acc_hi, '0);
    chk("R1", "mr_lo",  mr_lo,  '0);
    chk("R1", "pr_hi",  pr_hi,  '0);
    chk("R1", "mem_wdata", mem_wdata, '0);
  endtask

  task automatic t_load_add();
    step(3'b010, 0, 2'b00, 2'b00, 2'b10, 0, 18'd5);
    chk("R2", "acc_lo load from memory", acc_lo, 18'd5);
    // R11: result appears only after the edge
    x_sel = 3'b010; y_sel = 2'b10; wr_sel = 2'b10; half_hi = 0; mem_word = 18'd7;
    #1;
    chk("R11", "acc_lo before edge", acc_lo, 18'd5);
    @(posedge clk);
    @(negedge clk);
    wr_sel = 2'b00;
    chk("R3", "acc_lo mem+acc", acc_lo, 18'd12);
    chk("R8", "acc_hi untouched by low write", acc_hi, '0);
  endtask

  task automatic t_subtract();
    step(3'b010, 1, 2'b10, 2'b10, 2'b10, 0, 18'd5);
    chk("R6", "12-5", acc_lo, 18'd7);
    step(3'b010, 1, 2'b10, 2'b10, 2'b10, 0, 18'd9);
    chk("R6", "7-9 wraps", acc_lo, ONES - 18'd1);
  endtask

  task automatic t_two_word_add();
    step(3'b010, 0, 2'b00, 2'b00, 2'b10, 0, ONES);
    step(3'b010, 0, 2'b00, 2'b00, 2'b10, 1, 18'd1);
    chk("R8", "acc_hi load", acc_hi, 18'd1);
    chk("R8", "acc_lo kept on high write", acc_lo, ONES);
    step(3'b010, 0, 2'b10, 2'b00, 2'b10, 0, 18'd1);
    chk("R9", "low half sum", acc_lo, '0);
    step(3'b000, 0, 2'b00, 2'b00, 2'b00, 0, 18'd0);
    chk("R7", "no write leaves acc_lo", acc_lo, '0);
    step(3'b010, 0, 2'b10, 2'b01, 2'b10, 1, 18'd0);
    chk("R9", "high half takes saved carry", acc_hi, 18'd2);
  endtask

  task automatic t_two_word_sub();
    // acc = {2,0}; subtract {0,1}
    step(3'b010, 1, 2'b10, 2'b10, 2'b10, 0, 18'd1);
    chk("R9", "low half borrow", acc_lo, ONES);
    step(3'b010, 1, 2'b10, 2'b01, 2'b10, 1, 18'd0);
    chk("R5", "high half saved carry", acc_hi, 18'd1);
  endtask

  task automatic t_reserved_carry();
    // saved carry is 1 here; code 2'b11 must behave as carry-in 0
    step(3'b010, 0, 2'b10, 2'b11, 2'b10, 0, 18'd0);
    chk("R5", "unused carry code", acc_lo, ONES);
  endtask

  task automatic t_clear();
    step(3'b100, 1, 2'b10, 2'b10, 2'b10, 0, 18'd0);
    chk("R6", "clear low", acc_lo, '0);
    chk("R10", "memory word is old acc_lo", mem_wdata, ONES);
    step(3'b100, 1, 2'b10, 2'b10, 2'b10, 1, 18'd0);
    chk("R6", "clear high", acc_hi, '0);
    chk("R10", "memory word is old acc_hi", mem_wdata, 18'd1);
  endtask

  task automatic t_multiplier_load();
    step(3'b010, 0, 2'b00, 2'b00, 2'b01, 0, 18'h00f0f);
    chk("R7", "mr_lo written", mr_lo, 18'h00f0f);
    chk("R7", "acc_lo not written", acc_lo, '0);
    step(3'b010, 0, 2'b00, 2'b00, 2'b01, 1, 18'd3);
    chk("R8", "mr_hi written", mr_hi, 18'd3);
  endtask

  task automatic t_collate();
    step(3'b010, 0, 2'b00, 2'b00, 2'b10, 0, 18'd1);
    step(3'b100, 0, 2'b01, 2'b00, 2'b10, 0, 18'h000ff);
    chk("R3", "acc + (mr & mem)", acc_lo, 18'h00010);
  endtask

  task automatic t_product();
    step(3'b110, 0, 2'b11, 2'b00, 2'b11, 0, 18'd0, 1'b1, 1'b0);
    chk("R2", "mul source into pr", pr_lo, 18'h00f0f);
    step(3'b110, 0, 2'b11, 2'b00, 2'b11, 0, 18'd0, 1'b1, 1'b0);
    chk("R3", "pr accumulates", pr_lo, 18'h01e1e);
    step(3'b110, 0, 2'b11, 2'b00, 2'b11, 0, 18'd0, 1'b1, 1'b1);
    chk("R4", "first step drops pr", pr_lo, 18'h00f0f);
    step(3'b110, 0, 2'b11, 2'b00, 2'b11, 0, 18'd0, 1'b0, 1'b0);
    chk("R2", "step bit 0 gives zero X", pr_lo, 18'h00f0f);
    step(3'b001, 0, 2'b00, 2'b00, 2'b10, 0, 18'd0);
    chk("R2", "product as X", acc_lo, 18'h00f0f);
    chk("R7", "mr_lo unchanged", mr_lo, 18'h00f0f);
  endtask

  task automatic t_unused_x();
    step(3'b011, 0, 2'b00, 2'b00, 2'b10, 0, 18'd5);
    chk("R2", "unused X code is zero", acc_lo, '0);
    chk("R10", "memory word zero", mem_wdata, '0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_load_add();
    t_subtract();
    t_two_word_add();
    t_two_word_sub();
    t_reserved_carry();
    t_clear();
    t_multiplier_load();
    t_collate();
    t_product();
    t_unused_x();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule